// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node for a group of memory lines shared by several processors. Each line carries a coherence state, a sharer mask with one bit per processor, an owner id and a data word held inside the block. Processors send shared requests (read misses), exclusive requests (write misses), invalidation replies and write-backs. The block answers with shared replies, exclusive replies, invalidation requests and recall requests. All transactions are serialized here rather than on a bus.

One message is taken per clock on the request port. The answer, if there is one, is a registered message one cycle later. Destinations are given as a processor mask, so an invalidation to several sharers goes out as one multicast message. At most one transaction is waiting at any time, either for invalidation replies or for an owner's write-back. While it waits, new shared or exclusive requests are refused with `req_ready` low and stay with their sender. Invalidation replies and write-backs are always accepted.

Top module: `home_dir`

## Requirements
- R1: After reset every line is uncached (read-shared with an empty sharer mask) and holds a data word equal to its own line index. `out_valid` is low and `req_ready` is high.
- R2: Request kinds on `req_kind` are 0 = shared request, 1 = exclusive request, 2 = invalidation reply and 3 = write-back. Reply kinds on `out_kind` are 0 = shared reply, 1 = exclusive reply, 2 = invalidation request and 3 = recall. Bit i of `out_dst` addresses processor i.
- R2 (continued): A shared request to a read-shared line adds the requester to the sharer mask. In the next cycle it produces a shared reply to the requester, carrying the line's data and the request's line number.
- R3: An exclusive request to an uncached line, or from the only current sharer, is granted at once with an exclusive reply carrying the line data. The line becomes written-exclusive with the requester as owner.
- R4: An exclusive request to a read-shared line that has other sharers produces one invalidation message. Its `out_dst` is exactly the set of sharers other than the requester, and the line enters the wait-for-invalidation-replies state.
- R5: While a transaction waits, shared and exclusive requests see `req_ready` low and are not consumed. Invalidation replies and write-backs see `req_ready` high.
- R6: Each invalidation reply removes its sender from the sharer mask, with no output while sharers remain. The reply that empties the mask yields an exclusive reply to the waiting requester with the line data, and the requester becomes the owner.
- R7: A shared or exclusive request to a written-exclusive line sends a recall to the owner. When the owner's write-back arrives, its data replaces the line's data and the waiting request is served with that data. A shared request then leaves the line read-shared with only the requester as sharer; an exclusive request leaves the requester as owner.
- R8: An invalidation reply to a line that is not waiting for replies, or a write-back to a line that is not waiting for that owner, produces no output and changes neither the line's data nor its sharers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming message present |
| req_ready | output | 1 | Incoming message is consumed this cycle |
| req_kind | input | 2 | Incoming message kind |
| req_src | input | $clog2(NPROC) | Sending processor id |
| req_line | input | $clog2(NLINES) | Line number |
| req_data | input | DW | Write-back data |
| out_valid | output | 1 | Outgoing message present (one cycle) |
| out_kind | output | 2 | Outgoing message kind |
| out_dst | output | NPROC | Destination processor mask |
| out_line | output | $clog2(NLINES) | Line number of the outgoing message |
| out_data | output | DW | Line data for replies |

## Verification
The bench builds the block with its defaults: four processors, sixteen lines and a 16-bit data word. With four processors, a sharer set can hold two sites besides the requester, so a multicast mask with several bits is reached. An invalidation reply from a site that never shared the line is also reached. With sixteen lines the last index (15) is reached, and the reset data pattern lets each line's contents be told apart. A write-back value different from every index shows that memory was updated before the waiting request was served.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;
  typedef enum logic [1:0] {
    LN_SHARED = 2'd0,
    LN_EXCL   = 2'd1,
    LN_TINV   = 2'd2,
    LN_TWB    = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    IN_SHREQ = 2'd0,
    IN_EXREQ = 2'd1,
    IN_INVRP = 2'd2,
    IN_WBACK = 2'd3
  } in_kind_t;

  typedef enum logic [1:0] {
    OUT_SHREP  = 2'd0,
    OUT_EXREP  = 2'd1,
    OUT_INV    = 2'd2,
    OUT_RECALL = 2'd3
  } out_kind_t;
endpackage

// File: rtl/home_dir_store.sv
module home_dir_store
  import home_dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  parameter int DW     = 16,
  localparam int IDW   = $clog2(NPROC),
  localparam int LW    = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    rd_line,
  output line_st_t         rd_st,
  output logic [NPROC-1:0] rd_sh,
  output logic [IDW-1:0]   rd_own,
  output logic [DW-1:0]    rd_dat,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_line,
  input  line_st_t         wr_st,
  input  logic [NPROC-1:0] wr_sh,
  input  logic [IDW-1:0]   wr_own,
  input  logic [DW-1:0]    wr_dat
);
  line_st_t         st_q  [NLINES];
  logic [NPROC-1:0] sh_q  [NLINES];
  logic [IDW-1:0]   own_q [NLINES];
  logic [DW-1:0]    dat_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= LN_SHARED;
        sh_q[i]  <= '0;
        own_q[i] <= '0;
        dat_q[i] <= DW'(i);
      end
    end else if (wr_en) begin
      st_q[wr_line]  <= wr_st;
      sh_q[wr_line]  <= wr_sh;
      own_q[wr_line] <= wr_own;
      dat_q[wr_line] <= wr_dat;
    end
  end

  assign rd_st  = st_q[rd_line];
  assign rd_sh  = sh_q[rd_line];
  assign rd_own = own_q[rd_line];
  assign rd_dat = dat_q[rd_line];
endmodule

// File: rtl/home_dir_engine.sv
module home_dir_engine
  import home_dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  parameter int DW     = 16,
  localparam int IDW   = $clog2(NPROC),
  localparam int LW    = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [IDW-1:0]   req_src,
  input  logic [LW-1:0]    req_line,
  input  logic [DW-1:0]    req_data,
  input  line_st_t         rd_st,
  input  logic [NPROC-1:0] rd_sh,
  input  logic [IDW-1:0]   rd_own,
  input  logic [DW-1:0]    rd_dat,
  output logic             wr_en,
  output line_st_t         wr_st,
  output logic [NPROC-1:0] wr_sh,
  output logic [IDW-1:0]   wr_own,
  output logic [DW-1:0]    wr_dat,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [NPROC-1:0] out_dst,
  output logic [LW-1:0]    out_line,
  output logic [DW-1:0]    out_data,
  output logic             busy,
  output logic             ev_fire
);
  function automatic logic [NPROC-1:0] site_mask(input logic [IDW-1:0] id);
    logic [NPROC-1:0] m;
    m = '0;
    m[id] = 1'b1;
    return m;
  endfunction

  function automatic logic [NPROC-1:0] others_of(input logic [NPROC-1:0] sh,
                                                 input logic [IDW-1:0] id);
    return sh & ~site_mask(id);
  endfunction

  logic             busy_q, nx_busy;
  logic [IDW-1:0]   pend_src_q;
  logic             pend_sh_q;
  logic             ld_pend;
  logic             nx_ov;
  out_kind_t        nx_kind;
  logic [NPROC-1:0] nx_dst;
  logic [DW-1:0]    nx_data;
  logic [NPROC-1:0] others;

  assign busy      = busy_q;
  assign req_ready = !busy_q || req_kind[1];
  assign ev_fire   = req_valid && req_ready;
  assign others    = others_of(rd_sh, req_src);

  always_comb begin
    wr_en   = 1'b0;
    wr_st   = rd_st;
    wr_sh   = rd_sh;
    wr_own  = rd_own;
    wr_dat  = rd_dat;
    nx_ov   = 1'b0;
    nx_kind = OUT_SHREP;
    nx_dst  = '0;
    nx_data = rd_dat;
    nx_busy = busy_q;
    ld_pend = 1'b0;
    if (ev_fire) begin
      case (in_kind_t'(req_kind))
        IN_SHREQ, IN_EXREQ: begin
          wr_en = 1'b1;
          nx_ov = 1'b1;
          if (rd_st == LN_EXCL) begin
            wr_st   = LN_TWB;
            nx_kind = OUT_RECALL;
            nx_dst  = site_mask(rd_own);
            nx_busy = 1'b1;
            ld_pend = 1'b1;
          end else if (req_kind == IN_SHREQ) begin
            wr_sh  = rd_sh | site_mask(req_src);
            nx_dst = site_mask(req_src);
          end else if (others == '0) begin
            wr_st   = LN_EXCL;
            wr_sh   = '0;
            wr_own  = req_src;
            nx_kind = OUT_EXREP;
            nx_dst  = site_mask(req_src);
          end else begin
            wr_st   = LN_TINV;
            wr_sh   = others;
            nx_kind = OUT_INV;
            nx_dst  = others;
            nx_busy = 1'b1;
            ld_pend = 1'b1;
          end
        end
        IN_INVRP: begin
          if (rd_st == LN_TINV) begin
            wr_en = 1'b1;
            wr_sh = others;
            if (others == '0) begin
              wr_st   = LN_EXCL;
              wr_own  = pend_src_q;
              nx_ov   = 1'b1;
              nx_kind = OUT_EXREP;
              nx_dst  = site_mask(pend_src_q);
              nx_busy = 1'b0;
            end
          end
        end
        default: begin
          if (rd_st == LN_TWB && req_src == rd_own) begin
            wr_en   = 1'b1;
            wr_dat  = req_data;
            nx_data = req_data;
            nx_ov   = 1'b1;
            nx_dst  = site_mask(pend_src_q);
            nx_busy = 1'b0;
            if (pend_sh_q) begin
              wr_st   = LN_SHARED;
              wr_sh   = site_mask(pend_src_q);
              nx_kind = OUT_SHREP;
            end else begin
              wr_st   = LN_EXCL;
              wr_sh   = '0;
              wr_own  = pend_src_q;
              nx_kind = OUT_EXREP;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pend_src_q <= '0;
      pend_sh_q  <= 1'b0;
      out_valid  <= 1'b0;
      out_kind   <= '0;
      out_dst    <= '0;
      out_line   <= '0;
      out_data   <= '0;
    end else begin
      busy_q    <= nx_busy;
      out_valid <= nx_ov;
      out_kind  <= nx_kind;
      out_dst   <= nx_dst;
      out_line  <= req_line;
      out_data  <= nx_data;
      if (ld_pend) begin
        pend_src_q <= req_src;
        pend_sh_q  <= (req_kind == IN_SHREQ);
      end
    end
  end
endmodule

// File: rtl/home_dir.sv
module home_dir
  import home_dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  parameter int DW     = 16,
  localparam int IDW   = $clog2(NPROC),
  localparam int LW    = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [IDW-1:0]   req_src,
  input  logic [LW-1:0]    req_line,
  input  logic [DW-1:0]    req_data,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [NPROC-1:0] out_dst,
  output logic [LW-1:0]    out_line,
  output logic [DW-1:0]    out_data
);
  line_st_t         rd_st, wr_st;
  logic [NPROC-1:0] rd_sh, wr_sh;
  logic [IDW-1:0]   rd_own, wr_own;
  logic [DW-1:0]    rd_dat, wr_dat;
  logic             wr_en;
  logic             busy;
  logic             ev_fire;

  home_dir_store #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_line(req_line), .rd_st(rd_st), .rd_sh(rd_sh), .rd_own(rd_own), .rd_dat(rd_dat),
    .wr_en(wr_en), .wr_line(req_line), .wr_st(wr_st), .wr_sh(wr_sh),
    .wr_own(wr_own), .wr_dat(wr_dat)
  );

  home_dir_engine #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_line(req_line), .req_data(req_data),
    .rd_st(rd_st), .rd_sh(rd_sh), .rd_own(rd_own), .rd_dat(rd_dat),
    .wr_en(wr_en), .wr_st(wr_st), .wr_sh(wr_sh), .wr_own(wr_own), .wr_dat(wr_dat),
    .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst),
    .out_line(out_line), .out_data(out_data),
    .busy(busy), .ev_fire(ev_fire)
  );
endmodule

// File: rtl/home_dir_chk.sv
module home_dir_chk #(
  parameter int NPROC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_kind,
  input logic             out_valid,
  input logic [1:0]       out_kind,
  input logic [NPROC-1:0] out_dst,
  input logic             busy,
  input logic             ev_fire
);
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_ready);

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !req_kind[1] |-> !req_ready);

  p_reply_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_kind == 2'd0 || out_kind == 2'd1 || out_kind == 2'd3) |-> $onehot(out_dst));

  p_inv_fanout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd2 |-> busy && out_dst != '0);

  p_recall_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd3 |-> busy);

  p_release_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid && !out_kind[1]);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_fire |=> !out_valid);
endmodule

bind home_dir home_dir_chk #(.NPROC(NPROC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .out_valid(out_valid), .out_kind(out_kind),
  .out_dst(out_dst), .busy(busy), .ev_fire(ev_fire)
);

// File: tb/home_dir_tb.sv
module home_dir_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_src = '0;
  logic [3:0]  req_line = '0;
  logic [15:0] req_data = '0;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [3:0]  out_dst;
  logic [3:0]  out_line;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  logic        g_rdy, g_ov;
  logic [1:0]  g_kind;
  logic [3:0]  g_dst, g_line;
  logic [15:0] g_dat;

  always #5 clk = ~clk;

  home_dir u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_line(req_line), .req_data(req_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst),
    .out_line(out_line), .out_data(out_data)
  );

  task automatic check(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Drive one message at a falling edge; ready is sampled before the rising
  // edge, the registered answer at the following falling edge.
  task automatic send(input logic [1:0] k, input int src, input int ln, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_src   = src[1:0];
    req_line  = ln[3:0];
    req_data  = d;
    #1 g_rdy = req_ready;
    @(negedge clk);
    g_ov   = out_valid;
    g_kind = out_kind;
    g_dst  = out_dst;
    g_line = out_line;
    g_dat  = out_data;
    req_valid = 1'b0;
  endtask

  task automatic expect_msg(input string rq, input logic [1:0] k, input logic [3:0] dst,
                            input int ln, input logic [15:0] d);
    check(rq, "ready", {31'd0, g_rdy}, 32'd1);
    check(rq, "out_valid", {31'd0, g_ov}, 32'd1);
    check(rq, "kind", {30'd0, g_kind}, {30'd0, k});
    check(rq, "dst", {28'd0, g_dst}, {28'd0, dst});
    check(rq, "line", {28'd0, g_line}, ln);
    if (k != 2'd2 && k != 2'd3) check(rq, "data", {16'd0, g_dat}, {16'd0, d});
  endtask

  task automatic expect_none(input string rq, input logic rdy);
    check(rq, "ready", {31'd0, g_rdy}, {31'd0, rdy});
    check(rq, "no output", {31'd0, g_ov}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "reset ready", {31'd0, req_ready}, 32'd1);
    send(2'd0, 0, 3, 16'h0);
    expect_msg("R1/R2", 2'd0, 4'b0001, 3, 16'd3);
    send(2'd0, 3, 15, 16'h0);
    expect_msg("R1", 2'd0, 4'b1000, 15, 16'd15);
  endtask

  task automatic t_inv_flow();
    send(2'd0, 2, 3, 16'h0);
    expect_msg("R2", 2'd0, 4'b0100, 3, 16'd3);
    send(2'd1, 1, 3, 16'h0);
    expect_msg("R4", 2'd2, 4'b0101, 3, 16'h0);
    send(2'd0, 3, 3, 16'h0);
    expect_none("R5 shared held", 1'b0);
    send(2'd2, 0, 3, 16'h0);
    expect_none("R6 first inv reply", 1'b1);
    send(2'd2, 3, 3, 16'h0);
    expect_none("R8 non-sharer inv reply", 1'b1);
    send(2'd2, 2, 3, 16'h0);
    expect_msg("R6", 2'd1, 4'b0010, 3, 16'd3);
  endtask

  task automatic t_recall_shared();
    send(2'd0, 0, 3, 16'h0);
    expect_msg("R7 recall", 2'd3, 4'b0010, 3, 16'h0);
    send(2'd1, 2, 5, 16'h0);
    expect_none("R5 exclusive held", 1'b0);
    send(2'd3, 1, 3, 16'hABCD);
    expect_msg("R7 shared after wb", 2'd0, 4'b0001, 3, 16'hABCD);
    send(2'd1, 0, 3, 16'h0);
    expect_msg("R3 sole sharer", 2'd1, 4'b0001, 3, 16'hABCD);
  endtask

  task automatic t_recall_excl();
    send(2'd1, 2, 7, 16'h0);
    expect_msg("R3 uncached", 2'd1, 4'b0100, 7, 16'd7);
    send(2'd1, 3, 7, 16'h0);
    expect_msg("R7 recall excl", 2'd3, 4'b0100, 7, 16'h0);
    send(2'd3, 1, 7, 16'h1111);
    expect_none("R8 wb from non-owner", 1'b1);
    send(2'd3, 2, 7, 16'h0077);
    expect_msg("R7 excl after wb", 2'd1, 4'b1000, 7, 16'h0077);
  endtask

  task automatic t_stray();
    send(2'd3, 1, 9, 16'hDEAD);
    expect_none("R8 stray wb", 1'b1);
    send(2'd2, 1, 9, 16'h0);
    expect_none("R8 stray inv reply", 1'b1);
    send(2'd0, 1, 9, 16'h0);
    expect_msg("R8 data kept", 2'd0, 4'b0010, 9, 16'd9);
    send(2'd1, 2, 9, 16'h0);
    expect_msg("R8 sharers kept", 2'd2, 4'b0010, 9, 16'h0);
    send(2'd2, 1, 9, 16'h0);
    expect_msg("R6 single", 2'd1, 4'b0100, 9, 16'd9);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inv_flow();
    t_recall_shared();
    t_recall_excl();
    t_stray();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule